// File: doc/BRIEF.md
# Bipolar-Zero Staircase Pattern Source

This block produces an endless stream of signed test samples that probes how a digital-to-analog converter behaves in the few codes around zero. It starts each pass with a stretch of pure zero. It then runs a series of square-wave segments. In segment n the output swings between +n LSB and -n LSB. Every segment lasts the same number of square-wave periods, and each segment's amplitude is one LSB larger than the one before. After the largest amplitude it goes back to the zero stretch and repeats.

Every sample leaves the block as a 20-bit two's-complement word on a three-wire serial link: a bit clock, a data line and a latch strobe. A word takes 24 bit-clock slots: four zero pad bits, then the 20 data bits with the most significant bit first. The receiver shifts data on the rising bit-clock edge and takes the last 20 bits when the strobe falls. So one word per 24 bit clocks sets the sample rate. The system-clock divider that makes the bit clock, the number of samples per period, the number of periods per segment and the peak amplitude are all parameters. The current segment, period and amplitude are visible on outputs, and a one-cycle pulse marks every wrap back to the zero stretch.

Top module: `bz_stair_gen`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, all state is cleared. After reset, `bit_clk`, `bit_data`, `word_latch`, `restart`, `seg_idx`, `period_idx` and `amp_lsb` are all 0.
- R2: The first PERIOD*DWELL words after reset, and the same number of words at the start of each pass, all carry the value 0.
- R3: In segment n (1..MAX_AMP) every period has PERIOD words. The first PERIOD/2 words are +n and the rest are -n, coded as 20-bit two's complement (for example -1 = 0xFFFFF).
- R4: `period_idx` counts the periods of a segment from 0 to DWELL-1. `seg_idx` and `amp_lsb` rise by one after each DWELL periods. Both equal the amplitude n of the samples the sequencer is producing.
- R5: After segment MAX_AMP the pattern goes back to the zero segment. `restart` is high for exactly one `clk` cycle at that wrap: the cycle in which the counters return to 0.
- R6: A word takes 24 bit-clock slots. Slots 0 to 3 carry 0 and slots 4 to 23 carry the sample, most significant bit first. `bit_data` changes only when `bit_clk` falls, so it is stable on every rising edge.
- R7: `word_latch` is low in slots 0 to 1 and high in slots 2 to 23. It falls just after the rising edge that carries a word's least significant bit. The receiver therefore sees exactly 24 rising edges from one strobe fall to the next, and 2 rising edges from a fall to the following rise.
- R8: `bit_clk` holds each level for exactly HALF_DIV `clk` cycles.
- R9: A reset in the middle of the pattern makes the next words start again from the first zero word of a pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | output | 1 | Serial bit clock; the receiver samples on its rising edge |
| bit_data | output | 1 | Serial data, pad bits then the sample MSB first |
| word_latch | output | 1 | Latch strobe; the falling edge transfers the last 20 bits |
| seg_idx | output | SEG_W | Current segment (0 = zero stretch) |
| period_idx | output | PER_W | Period count within the current segment |
| amp_lsb | output | SEG_W | Current amplitude in LSB |
| restart | output | 1 | One-cycle pulse when the pattern wraps to the zero segment |

## Verification
On every cycle, assertions check the following. The segment register steps by one after the last sample of its final period. The restart pulse follows the last sample of the largest segment and puts the counters back to zero. The sequencer never moves without a word request, and word requests never come on two cycles in a row. Serial data changes only on falling bit-clock edges. The strobe rises and falls only at its fixed slot positions. What the assertions cannot see is the content of the stream. Decoded word values, sign order inside a period, the zero pad bits, the bit-clock level widths, the position of the restart pulse in the word sequence and the restart after a mid-pattern reset are shown only by the bench's scenarios, which decode the serial stream as a receiver would.

// File: rtl/bz_stair_pkg.sv
package bz_stair_pkg;

    // serial word layout
    localparam int SAMPLE_W   = 20;
    localparam int PAD_W      = 4;
    localparam int FRAME_W    = SAMPLE_W + PAD_W;
    localparam int SLOT_W     = $clog2(FRAME_W);
    localparam int LATCH_LOW  = 2;   // slots at the start of a frame with the strobe low
    localparam int MAG_W      = 16;  // widest amplitude the sample builder accepts

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [FRAME_W-1:0]         frame_t;

    // which half of a square-wave period is playing
    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    // what the sequencer hands to the serializer
    typedef struct packed {
        half_e            half;
        logic [MAG_W-1:0] mag;
    } tone_t;

    // signed sample from a magnitude and a half-period selector
    function automatic sample_t mk_sample(input tone_t t);
        sample_t m;
        m = sample_t'(t.mag);
        return (t.half == HALF_NEG) ? -m : m;
    endfunction

    // pad bits go first, then the sample MSB first
    function automatic frame_t mk_frame(input sample_t s);
        return {{PAD_W{1'b0}}, s};
    endfunction

endpackage

// File: rtl/bz_bitclk.sv
module bz_bitclk #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic bclk_o,
    output logic fall_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic             bclk_q;
    logic             flip;

    assign flip   = (div_q == DIV_LAST);
    assign fall_o = flip && bclk_q;
    assign bclk_o = bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
        end else if (flip) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            div_q  <= div_q + DIV_ONE;
        end
    end

    // R8
    bclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flip |=> $stable(bclk_q));

endmodule

// File: rtl/bz_seq.sv
module bz_seq
    import bz_stair_pkg::*;
#(
    parameter int PERIOD  = 8,
    parameter int DWELL   = 10,
    parameter int MAX_AMP = 10,
    localparam int SEG_W  = (MAX_AMP > 0) ? $clog2(MAX_AMP + 1) : 1,
    localparam int PER_W  = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output sample_t          sample_o,
    output logic [SEG_W-1:0] seg_o,
    output logic [PER_W-1:0] per_o,
    output logic [SEG_W-1:0] amp_o,
    output logic             sos_o
);
    localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(PERIOD / 2);
    localparam logic [PH_W-1:0]  PH_ONE   = PH_W'(1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(DWELL - 1);
    localparam logic [PER_W-1:0] PER_ONE  = PER_W'(1);
    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(MAX_AMP);
    localparam logic [SEG_W-1:0] SEG_ONE  = SEG_W'(1);

    logic [PH_W-1:0]  phase_q;
    logic [PER_W-1:0] per_q;
    logic [SEG_W-1:0] seg_q;
    logic [SEG_W-1:0] amp_q;
    logic             sos_q;
    logic             end_period;
    logic             end_segment;
    tone_t            tone;

    assign end_period  = adv_i && (phase_q == PH_LAST);
    assign end_segment = end_period && (per_q == PER_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            per_q   <= '0;
            seg_q   <= '0;
            amp_q   <= '0;
            sos_q   <= 1'b0;
        end else begin
            sos_q <= 1'b0;
            if (adv_i) begin
                if (!end_period) begin
                    phase_q <= phase_q + PH_ONE;
                end else begin
                    phase_q <= '0;
                    if (!end_segment) begin
                        per_q <= per_q + PER_ONE;
                    end else begin
                        per_q <= '0;
                        if (seg_q == SEG_LAST) begin
                            seg_q <= '0;
                            amp_q <= '0;
                            sos_q <= 1'b1;
                        end else begin
                            seg_q <= seg_q + SEG_ONE;
                            amp_q <= amp_q + SEG_ONE;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        tone.half = (phase_q >= PH_HALF) ? HALF_NEG : HALF_POS;
        tone.mag  = MAG_W'(amp_q);
    end

    assign sample_o = mk_sample(tone);
    assign seg_o    = seg_q;
    assign per_o    = per_q;
    assign amp_o    = amp_q;
    assign sos_o    = sos_q;

    // R4
    seg_step_chk: assert property (@(posedge clk) disable iff (rst)
        (end_segment && seg_q != SEG_LAST) |=> (seg_q == $past(seg_q) + SEG_ONE));

    // R5
    wrap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (end_segment && seg_q == SEG_LAST) |=> (sos_q && seg_q == '0 && per_q == '0));

    // R5
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        sos_q |=> !sos_q);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> ($stable(phase_q) && $stable(per_q) && $stable(seg_q)));

endmodule

// File: rtl/bz_ser.sv
module bz_ser
    import bz_stair_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bclk_i,
    input  logic    fall_i,
    input  sample_t sample_i,
    output logic    adv_o,
    output logic    data_o,
    output logic    latch_o
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_ONE  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] LE_SLOT   = SLOT_W'(LATCH_LOW);
    localparam logic [SLOT_W-1:0] LE_PREV   = SLOT_W'(LATCH_LOW - 1);

    logic [SLOT_W-1:0] slot_q;
    frame_t            shreg_q;
    frame_t            frame;
    logic              data_q;
    logic              latch_q;
    logic              wrap;

    assign wrap  = (slot_q == SLOT_LAST);
    assign adv_o = fall_i && wrap;

    always_comb begin
        if (wrap) frame = mk_frame(sample_i);
        else      frame = shreg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_LAST;
            shreg_q <= '0;
            data_q  <= 1'b0;
            latch_q <= 1'b0;
        end else if (fall_i) begin
            slot_q  <= wrap ? '0 : slot_q + SLOT_ONE;
            data_q  <= frame[FRAME_W-1];
            shreg_q <= frame << 1;
            if (wrap)
                latch_q <= 1'b0;
            else if (slot_q == LE_PREV)
                latch_q <= 1'b1;
        end
    end

    assign data_o  = data_q;
    assign latch_o = latch_q;

    // R6
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $fell(bclk_i));

    // R7
    latch_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_q) |-> (slot_q == '0));

    // R7
    latch_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> (slot_q == LE_SLOT));

    // R7
    adv_single_chk: assert property (@(posedge clk) disable iff (rst)
        adv_o |=> !adv_o);

endmodule

// File: rtl/bz_stair_gen.sv
module bz_stair_gen
    import bz_stair_pkg::*;
#(
    parameter int PERIOD   = 8,
    parameter int DWELL    = 10,
    parameter int MAX_AMP  = 10,
    parameter int HALF_DIV = 4,
    localparam int SEG_W   = (MAX_AMP > 0) ? $clog2(MAX_AMP + 1) : 1,
    localparam int PER_W   = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             bit_clk,
    output logic             bit_data,
    output logic             word_latch,
    output logic [SEG_W-1:0] seg_idx,
    output logic [PER_W-1:0] period_idx,
    output logic [SEG_W-1:0] amp_lsb,
    output logic             restart
);
    logic    fall;
    logic    adv;
    sample_t sample;

    bz_bitclk #(
        .HALF_DIV (HALF_DIV)
    ) u_bitclk (
        .clk    (clk),
        .rst    (rst),
        .bclk_o (bit_clk),
        .fall_o (fall)
    );

    bz_seq #(
        .PERIOD  (PERIOD),
        .DWELL   (DWELL),
        .MAX_AMP (MAX_AMP)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .adv_i    (adv),
        .sample_o (sample),
        .seg_o    (seg_idx),
        .per_o    (period_idx),
        .amp_o    (amp_lsb),
        .sos_o    (restart)
    );

    bz_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .bclk_i   (bit_clk),
        .fall_i   (fall),
        .sample_i (sample),
        .adv_o    (adv),
        .data_o   (bit_data),
        .latch_o  (word_latch)
    );

endmodule

// File: tb/tb_bz_stair_gen.sv
module tb_bz_stair_gen;

    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int D   = 3;
    localparam int MX  = 4;
    localparam int HD  = 2;
    localparam int LOOP = P * D * (MX + 1);
    localparam int SW  = $clog2(MX + 1);
    localparam int PW  = (D > 1) ? $clog2(D) : 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_clk, bit_data, word_latch, restart;
    logic [SW-1:0] seg_idx, amp_lsb;
    logic [PW-1:0] period_idx;

    int total = 0;
    int bad   = 0;
    logic prev_bclk, prev_le;
    logic [23:0] sh_tb;
    int rises, lat_cnt, lvl_cnt, sos_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    bz_stair_gen #(.PERIOD(P), .DWELL(D), .MAX_AMP(MX), .HALF_DIV(HD)) dut (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .bit_data(bit_data),
        .word_latch(word_latch), .seg_idx(seg_idx), .period_idx(period_idx),
        .amp_lsb(amp_lsb), .restart(restart)
    );

    function automatic int seg_of(input int k);
        return (k / (P * D)) % (MX + 1);
    endfunction

    function automatic int per_of(input int k);
        return (k / P) % D;
    endfunction

    function automatic logic [19:0] exp_word(input int k);
        int v;
        v = seg_of(k);
        if ((k % P) >= P / 2) v = -v;
        return 20'(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_dut(input string req);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(bit_clk == 1'b0 && bit_data == 1'b0 && word_latch == 1'b0, req,
              "serial lines after reset", int'({bit_clk, bit_data, word_latch}), 0);
        check(seg_idx == '0 && period_idx == '0 && amp_lsb == '0 && restart == 1'b0, req,
              "counters after reset", int'(seg_idx) + int'(period_idx) + int'(amp_lsb), 0);
        prev_bclk = 1'b0;
        prev_le   = 1'b0;
        sh_tb     = '0;
        rises     = 0;
        lat_cnt   = 0;
        lvl_cnt   = 1;
        sos_cnt   = 0;
    endtask

    // decode n words as a receiver would and check every one of them
    task automatic run_words(input int n, input string tag);
        int target;
        int guard;
        bit latch_now;
        string rq;
        target = lat_cnt + n;
        guard  = 0;
        while (lat_cnt < target && guard < 40000) begin
            @(negedge clk);
            guard++;
            latch_now = 1'b0;
            if (bit_clk != prev_bclk) begin
                check(lvl_cnt == HD, "R8", "bit clock level width", lvl_cnt, HD);
                lvl_cnt = 1;
            end else begin
                lvl_cnt++;
            end
            if (bit_clk && !prev_bclk) begin
                sh_tb = {sh_tb[22:0], bit_data};
                rises++;
            end
            if (word_latch && !prev_le && lat_cnt > 0)
                check(rises == 2, "R7", "rising edges before strobe rise", rises, 2);
            if (!word_latch && prev_le) begin
                latch_now = 1'b1;
                if (lat_cnt > 0)
                    check(rises == 24, "R7", "rising edges per word", rises, 24);
                rq = (tag != "") ? tag : ((seg_of(lat_cnt) == 0) ? "R2" : "R3");
                check(sh_tb[19:0] == exp_word(lat_cnt), rq, "word value",
                      int'(sh_tb[19:0]), int'(exp_word(lat_cnt)));
                check(sh_tb[23:20] == 4'h0, "R6", "pad bits", int'(sh_tb[23:20]), 0);
                check(int'(seg_idx) == seg_of(lat_cnt + 2) && int'(amp_lsb) == seg_of(lat_cnt + 2),
                      "R4", "segment and amplitude", int'(seg_idx), seg_of(lat_cnt + 2));
                check(int'(period_idx) == per_of(lat_cnt + 2), "R4", "period count",
                      int'(period_idx), per_of(lat_cnt + 2));
                lat_cnt++;
                rises = 0;
            end
            if (restart) begin
                sos_cnt++;
                check(latch_now && ((lat_cnt + 1) % LOOP == 0), "R5",
                      "restart pulse position (word index)", lat_cnt - 1, LOOP - 2);
            end
            prev_bclk = bit_clk;
            prev_le   = word_latch;
        end
        check(lat_cnt >= target, "R7", "words decoded", lat_cnt, target);
    endtask

    task automatic t_reset_state();
        reset_dut("R1");
    endtask

    task automatic t_zero_dwell();
        run_words(P * D, "");
    endtask

    task automatic t_staircase_and_wrap();
        run_words(2 * LOOP + 10 - P * D, "");
        check(sos_cnt == 2, "R5", "restart pulses over two passes", sos_cnt, 2);
    endtask

    task automatic t_mid_reset();
        run_words(P * D + 5, "");
        reset_dut("R9");
        run_words(P * D + 6, "R9");
    endtask

    initial begin
        t_reset_state();
        t_zero_dwell();
        t_staircase_and_wrap();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule